// File: doc/BRIEF.md
# Dual-Clock Width-Converting FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Storage is an array of 36-bit entries. Either port, but not both, may be narrowed to 18 or 9 bits. A narrow write port gathers lanes into one entry before committing it. A narrow read port hands an entry out one lane per read. This lets a wide producer feed a narrow consumer, or the reverse, without outside glue logic.

Four active-low status outputs report the fill level in whole 36-bit entries. Full and almost-full come from the write clock domain. Empty and almost-empty come from the read clock domain. The two almost thresholds sit in offset registers that are loaded through the write port while a load strobe is held low. Pointers cross between the domains as Gray code through two-stage synchronizers.

Top module: `wfx_fifo`

## Requirements
- R1: After reset, empty_n and almost_empty_n are 0, full_n and almost_full_n are 1, rd_data is 0, and both offset registers hold DEF_OFF (8).
- R2: With a 36-bit write port and a 9-bit read port, a stored entry is returned as four lanes, bits 8:0 first, then 17:9, 26:18 and 35:27. Each lane appears on rd_data after the read-clock edge that sampled rd_en_n low.
- R3: With a 9-bit write port and a 36-bit read port, four written lanes form one entry. The first lane fills bits 8:0 and the fourth fills bits 35:27.
- R4: A read while empty_n is 0 is ignored: rd_data keeps its value and no pointer moves.
- R5: full_n goes to 0 when 2**ADDR_W entries are stored. A write while full_n is 0 is ignored and never shows up on the read side.
- R6: almost_empty_n is 0 exactly when the stored entry count is at or below the almost-empty offset.
- R7: almost_full_n is 0 exactly when the count of free entries is at or below the almost-full offset.
- R8: While load_n is 0, each write-enabled cycle loads an offset from wr_data[ADDR_W:0] instead of storing data. The first such cycle loads the almost-empty offset and the second loads the almost-full offset.
- R9: Entries leave in the order they were written, including across pointer wraparound.
- R10: On a narrow read port, the read pointer moves only after the last lane of an entry is read. empty_n stays 1 until then.
- R11: On a narrow write port, an entry is committed only when its last lane is written. empty_n stays 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low offset-load strobe (write domain) |
| wr_data | input | 36/WR_LANES | Write data lane, or offset value while loading |
| full_n | output | 1 | Active-low full flag (write domain) |
| almost_full_n | output | 1 | Active-low almost-full flag (write domain) |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | 36/RD_LANES | Registered read data lane |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| almost_empty_n | output | 1 | Active-low almost-empty flag (read domain) |

## Verification
Write-domain flags come straight from the local write pointer, so they are due right after the write edge that commits an entry; the bench samples them at the next falling write edge. Read data and the read-side flags follow a read edge the same way: read data is registered and sampled one falling edge after the enable. Any result that must cross domains passes two synchronizer flops plus up to one edge of phase slip. The bench therefore waits six cycles of the receiving clock before it checks empty_n, almost_empty_n or a freed full_n. Checks that a partial entry is not yet visible use the same six-cycle wait, so a premature commit would already have crossed over.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
   localparam int WORD_W = 36;

   function automatic bit lanes_ok(input int wl, input int rl);
      return (wl == 1 && (rl == 1 || rl == 2 || rl == 4)) ||
             (rl == 1 && (wl == 2 || wl == 4));
   endfunction
endpackage

// File: rtl/wfx_gray_sync.sv
module wfx_gray_sync #(
   parameter int W = 5
) (
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   logic [W-1:0] meta_q;

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q_out  <= '0;
      end else begin
         meta_q <= d_in;
         q_out  <= meta_q;
      end
   end
endmodule

// File: rtl/wfx_wr_side.sv
module wfx_wr_side #(
   parameter int ADDR_W  = 4,
   parameter int LANES   = 1,
   parameter int DEF_OFF = 8
) (
   input  logic                         wr_clk,
   input  logic                         rst_n,
   input  logic                         wr_en_n,
   input  logic                         load_n,
   input  logic [wfx_pkg::WORD_W/LANES-1:0] wr_data,
   input  logic [ADDR_W:0]              rgray_s,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [wfx_pkg::WORD_W-1:0]   mem_wdata,
   output logic [ADDR_W:0]              wgray,
   output logic [ADDR_W:0]              ae_off,
   output logic                         full_n,
   output logic                         almost_full_n
);
   localparam int PW   = ADDR_W + 1;
   localparam int IN_W = wfx_pkg::WORD_W / LANES;
   localparam logic [PW-1:0] DEPTH_P = PW'(2 ** ADDR_W);

   logic [PW-1:0] wbin_q, wbin_nx, rbin_s, count_w, free_w, af_off_q;
   logic          accept, commit, load_sel_q;

   always_comb begin
      rbin_s[PW-1] = rgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign count_w       = wbin_q - rbin_s;
   assign free_w        = DEPTH_P - count_w;
   assign full_n        = (count_w != DEPTH_P);
   assign almost_full_n = (free_w > af_off_q);
   assign accept        = !wr_en_n && load_n && full_n;
   assign wbin_nx       = wbin_q + 1'b1;
   assign mem_addr      = wbin_q[ADDR_W-1:0];
   assign mem_we        = commit;

   // offset registers: almost-empty first, then almost-full
   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_off     <= PW'(DEF_OFF);
         af_off_q   <= PW'(DEF_OFF);
         load_sel_q <= 1'b0;
      end else if (!load_n) begin
         if (!wr_en_n) begin
            if (!load_sel_q) ae_off   <= wr_data[PW-1:0];
            else             af_off_q <= wr_data[PW-1:0];
            load_sel_q <= !load_sel_q;
         end
      end else begin
         load_sel_q <= 1'b0;
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q <= '0;
         wgray  <= '0;
      end else if (commit) begin
         wbin_q <= wbin_nx;
         wgray  <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   generate
      if (LANES == 1) begin : g_wide
         assign commit    = accept;
         assign mem_wdata = wr_data;
      end else begin : g_pack
         localparam int LW = $clog2(LANES);
         localparam logic [LW-1:0] LAST = LW'(LANES - 1);
         logic [LW-1:0]                      lane_q;
         logic [wfx_pkg::WORD_W-IN_W-1:0]    pack_q;

         assign commit    = accept && (lane_q == LAST);
         assign mem_wdata = {wr_data, pack_q};

         always_ff @(posedge wr_clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
               pack_q <= '0;
            end else if (accept) begin
               if (lane_q == LAST) begin
                  lane_q <= '0;
               end else begin
                  pack_q[int'(lane_q)*IN_W +: IN_W] <= wr_data;
                  lane_q <= lane_q + 1'b1;
               end
            end
         end

         assert_pack_hold_R11: assert property (@(posedge wr_clk) disable iff (!rst_n)
            (accept && lane_q != LAST) |=> $stable(wbin_q));
      end
   endgenerate

   assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n) |=> $stable(wbin_q));
   assert_load_no_entry_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!load_n) |=> $stable(wbin_q));
   assert_gray_step_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));
   assert_full_implies_af_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n) |-> (!almost_full_n));
endmodule

// File: rtl/wfx_rd_side.sv
module wfx_rd_side #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 1
) (
   input  logic                             rd_clk,
   input  logic                             rst_n,
   input  logic                             rd_en_n,
   input  logic [ADDR_W:0]                  wgray_s,
   input  logic [wfx_pkg::WORD_W-1:0]       mem_rdata,
   input  logic [ADDR_W:0]                  ae_off,
   output logic [ADDR_W-1:0]                mem_addr,
   output logic [wfx_pkg::WORD_W/LANES-1:0] rd_data,
   output logic                             empty_n,
   output logic                             almost_empty_n
);
   localparam int PW    = ADDR_W + 1;
   localparam int OUT_W = wfx_pkg::WORD_W / LANES;

   logic [PW-1:0]    rbin_q, rbin_nx, wbin_s, count_r;
   logic [PW-1:0]    rgray_q;
   logic [OUT_W-1:0] lane_data;
   logic             take, last_lane;

   always_comb begin
      wbin_s[PW-1] = wgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign count_r        = wbin_s - rbin_q;
   assign empty_n        = (count_r != '0);
   assign almost_empty_n = (count_r > ae_off);
   assign take           = !rd_en_n && empty_n;
   assign rbin_nx        = rbin_q + 1'b1;
   assign mem_addr       = rbin_q[ADDR_W-1:0];

   generate
      if (LANES == 1) begin : g_wide
         assign last_lane = 1'b1;
         assign lane_data = mem_rdata;
      end else begin : g_unpack
         localparam int LW = $clog2(LANES);
         localparam logic [LW-1:0] LAST = LW'(LANES - 1);
         logic [LW-1:0] lane_q;

         assign last_lane = (lane_q == LAST);
         assign lane_data = mem_rdata[int'(lane_q)*OUT_W +: OUT_W];

         always_ff @(posedge rd_clk or negedge rst_n) begin
            if (!rst_n)    lane_q <= '0;
            else if (take) lane_q <= last_lane ? '0 : lane_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         rd_data <= '0;
      end else if (take) begin
         rd_data <= lane_data;
         if (last_lane) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
         end
      end
   end

   assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n) |=> ($stable(rbin_q) && $stable(rd_data)));
   assert_lane_hold_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (take && !last_lane) |=> $stable(rbin_q));
   assert_empty_implies_ae_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n) |-> (!almost_empty_n));
endmodule

// File: rtl/wfx_fifo.sv
module wfx_fifo #(
   parameter int ADDR_W   = 4,
   parameter int WR_LANES = 1,
   parameter int RD_LANES = 4,
   parameter int DEF_OFF  = 8
) (
   input  logic                                rst_n,
   input  logic                                wr_clk,
   input  logic                                wr_en_n,
   input  logic                                load_n,
   input  logic [wfx_pkg::WORD_W/WR_LANES-1:0] wr_data,
   output logic                                full_n,
   output logic                                almost_full_n,
   input  logic                                rd_clk,
   input  logic                                rd_en_n,
   output logic [wfx_pkg::WORD_W/RD_LANES-1:0] rd_data,
   output logic                                empty_n,
   output logic                                almost_empty_n
);
   localparam int WORD_W = wfx_pkg::WORD_W;
   localparam int DEPTH  = 2 ** ADDR_W;
   localparam int PW     = ADDR_W + 1;

   generate
      if (!wfx_pkg::lanes_ok(WR_LANES, RD_LANES)) begin : g_bad_lanes
         $error("wfx_fifo: unsupported port width pair");
      end
      if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_depth
         $error("wfx_fifo: ADDR_W out of range");
      end
      if (DEF_OFF > DEPTH) begin : g_bad_off
         $error("wfx_fifo: DEF_OFF exceeds depth");
      end
      if (PW > WORD_W / WR_LANES) begin : g_bad_load
         $error("wfx_fifo: offset does not fit the write lane");
      end
   endgenerate

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic              mem_we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [WORD_W-1:0] wdata, rdata;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, ae_off;

   always_ff @(posedge wr_clk) begin
      if (mem_we) mem_q[waddr] <= wdata;
   end
   assign rdata = mem_q[raddr];

   wfx_wr_side #(.ADDR_W(ADDR_W), .LANES(WR_LANES), .DEF_OFF(DEF_OFF)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
      .wr_data(wr_data), .rgray_s(rgray_s), .mem_we(mem_we), .mem_addr(waddr),
      .mem_wdata(wdata), .wgray(wgray), .ae_off(ae_off), .full_n(full_n),
      .almost_full_n(almost_full_n));

   wfx_gray_sync #(.W(PW)) u_sync_w2r (
      .dst_clk(rd_clk), .rst_n(rst_n), .d_in(wgray), .q_out(wgray_s));

   wfx_gray_sync #(.W(PW)) u_sync_r2w (
      .dst_clk(wr_clk), .rst_n(rst_n), .d_in(rgray), .q_out(rgray_s));

   wfx_rd_side #(.ADDR_W(ADDR_W), .LANES(RD_LANES)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .wgray_s(wgray_s),
      .mem_rdata(rdata), .ae_off(ae_off), .mem_addr(raddr), .rd_data(rd_data),
      .empty_n(empty_n), .almost_empty_n(almost_empty_n));

   assign rgray = u_rd.rgray_q;
endmodule

// File: tb/wfx_fifo_tb_top.sv
module wfx_fifo_tb_top;
   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   always #2 wclk = ~wclk;   // 250 MHz write clock
   always #3 rclk = ~rclk;   // unrelated read clock

   int checks = 0, failures = 0;
   bit done = 1'b0;

   // wide-in / 9-bit-out instance
   logic a_wen = 1'b1, a_load = 1'b1, a_ren = 1'b1;
   logic [35:0] a_wd = '0;
   logic [8:0]  a_rd;
   logic a_full_n, a_af_n, a_empty_n, a_ae_n;

   // 9-bit-in / wide-out instance
   logic p_wen = 1'b1, p_load = 1'b1, p_ren = 1'b1;
   logic [8:0]  p_wd = '0;
   logic [35:0] p_rd;
   logic p_full_n, p_af_n, p_empty_n, p_ae_n;

   wfx_fifo #(.ADDR_W(4), .WR_LANES(1), .RD_LANES(4), .DEF_OFF(8)) dut_i (
      .rst_n(rst_n), .wr_clk(wclk), .wr_en_n(a_wen), .load_n(a_load), .wr_data(a_wd),
      .full_n(a_full_n), .almost_full_n(a_af_n), .rd_clk(rclk), .rd_en_n(a_ren),
      .rd_data(a_rd), .empty_n(a_empty_n), .almost_empty_n(a_ae_n));

   wfx_fifo #(.ADDR_W(4), .WR_LANES(4), .RD_LANES(1), .DEF_OFF(8)) dut_pack_i (
      .rst_n(rst_n), .wr_clk(wclk), .wr_en_n(p_wen), .load_n(p_load), .wr_data(p_wd),
      .full_n(p_full_n), .almost_full_n(p_af_n), .rd_clk(rclk), .rd_en_n(p_ren),
      .rd_data(p_rd), .empty_n(p_empty_n), .almost_empty_n(p_ae_n));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask
   task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask

   task automatic a_write(input logic [35:0] d);
      @(negedge wclk); a_wen = 1'b0; a_wd = d;
      @(negedge wclk); a_wen = 1'b1;
   endtask
   task automatic a_read(output logic [8:0] q);
      @(negedge rclk); a_ren = 1'b0;
      @(negedge rclk); a_ren = 1'b1; q = a_rd;
   endtask
   task automatic p_write(input logic [8:0] d);
      @(negedge wclk); p_wen = 1'b0; p_wd = d;
      @(negedge wclk); p_wen = 1'b1;
   endtask
   task automatic p_read(output logic [35:0] q);
      @(negedge rclk); p_ren = 1'b0;
      @(negedge rclk); p_ren = 1'b1; q = p_rd;
   endtask

   function automatic logic [35:0] pat(input int k);
      return {9'(k + 3), 9'(k * 5), 9'(~k), 9'(k ^ 'h155)};
   endfunction

   // read one entry as four lanes from dut_i, bits 8:0 first
   task automatic a_read_word(input logic [35:0] exp, input string req);
      logic [8:0] q;
      for (int i = 0; i < 4; i++) begin
         a_read(q);
         chk(req, q, exp[i*9 +: 9]);
      end
   endtask

   task automatic t_reset;
      wait_w(2);
      chk("R1 empty_n", a_empty_n, 0);
      chk("R1 almost_empty_n", a_ae_n, 0);
      chk("R1 full_n", a_full_n, 1);
      chk("R1 almost_full_n", a_af_n, 1);
      chk("R1 rd_data", a_rd, 0);
      chk("R1 pack empty_n", p_empty_n, 0);
      chk("R1 pack full_n", p_full_n, 1);
   endtask

   task automatic t_empty_read;
      logic [8:0] q; logic [35:0] qw;
      a_read(q);
      chk("R4 read while empty", q, 0);
      p_read(qw);
      chk("R4 pack read while empty", qw, 0);
   endtask

   task automatic t_unpack;
      logic [35:0] w = 36'h9_A5C3_1E27;
      logic [8:0] q;
      a_write(w);
      wait_r(6);
      chk("R2 entry visible", a_empty_n, 1);
      for (int i = 0; i < 4; i++) begin
         a_read(q);
         chk("R2 lane order", q, w[i*9 +: 9]);
         if (i < 3) chk("R10 entry held until last lane", a_empty_n, 1);
         else       chk("R10 empty after last lane", a_empty_n, 0);
      end
      a_read(q);
      chk("R4 rd_data held on empty read", q, w[35:27]);
   endtask

   task automatic t_pack;
      logic [8:0] l [4] = '{9'h1A3, 9'h0F5, 9'h12C, 9'h07E};
      logic [35:0] q;
      for (int i = 0; i < 3; i++) p_write(l[i]);
      wait_r(6);
      chk("R11 no commit before last lane", p_empty_n, 0);
      p_write(l[3]);
      wait_r(6);
      chk("R11 commit on last lane", p_empty_n, 1);
      p_read(q);
      chk("R3 packed lane order", q, {l[3], l[2], l[1], l[0]});
      chk("R3 empty after read", p_empty_n, 0);
   endtask

   task automatic t_fill;
      for (int k = 0; k < 16; k++) begin
         a_write(pat(k));
         if (k == 6)  chk("R7 almost_full_n free=9", a_af_n, 1);
         if (k == 7)  chk("R7 almost_full_n free=8", a_af_n, 0);
         if (k == 7)  begin wait_r(6); chk("R6 almost_empty_n count=8", a_ae_n, 0); end
         if (k == 8)  begin wait_r(6); chk("R6 almost_empty_n count=9", a_ae_n, 1); end
         if (k == 14) chk("R5 full_n count=15", a_full_n, 1);
      end
      chk("R5 full_n count=16", a_full_n, 0);
      a_write(36'hF_FFFF_FFFF);
      chk("R5 full_n after extra write", a_full_n, 0);
      wait_r(6);
      for (int k = 0; k < 16; k++) a_read_word(pat(k), "R9 order across wrap");
      chk("R5 extra write dropped", a_empty_n, 0);
      wait_w(6);
      chk("R5 full_n after drain", a_full_n, 1);
      chk("R7 almost_full_n after drain", a_af_n, 1);
   endtask

   task automatic t_load;
      @(negedge wclk); a_load = 1'b0;
      a_write(36'd3);
      a_write(36'd12);
      @(negedge wclk); a_load = 1'b1;
      wait_r(6);
      chk("R8 loads store no data", a_empty_n, 0);
      for (int k = 0; k < 3; k++) a_write(pat(20 + k));
      chk("R8 af offset 12 free=13", a_af_n, 1);
      wait_r(6);
      chk("R8 ae offset 3 count=3", a_ae_n, 0);
      a_write(pat(23));
      chk("R8 af offset 12 free=12", a_af_n, 0);
      wait_r(6);
      chk("R8 ae offset 3 count=4", a_ae_n, 1);
      for (int k = 0; k < 4; k++) a_read_word(pat(20 + k), "R8 data after load");
      chk("R8 empty after drain", a_empty_n, 0);
   endtask

   initial begin
      #25 rst_n = 1'b1;
      t_reset();
      t_empty_read();
      t_unpack();
      t_pack();
      t_fill();
      t_load();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge wclk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule